// File: doc/BRIEF.md
# Segment Descriptor Cache and Access Checker

This block turns a (segment slot, offset) pair into a 32-bit linear address under protected-mode segmentation. Software-visible segment slots are loaded with a 16-bit selector. A load reads the 8-byte descriptor that the selector points at from the global table, or from the local table, through a simple read port. It then keeps the base, the limit, the granularity flag and the rights byte in a hidden per-slot cache. Every later access uses only that cached copy and never touches memory.

Each access is checked in a fixed order: is the slot unusable (null), does the access run past the effective segment limit, and is it misaligned (only when alignment checking is switched on). The result is a linear address and a 3-bit fault code one cycle after the access is accepted. The local table is itself described by a descriptor in the global table. A dedicated load of the local-table register fetches that descriptor and caches it. The global table's base and byte limit are plain inputs.

Selector layout: bits 15:3 are the table index, bit 2 chooses the table (0 global, 1 local), and bits 1:0 carry a requested privilege that this block ignores. Descriptor layout: the word at the lower address is the 32-bit base. In the upper word, bits 19:0 are the limit, bit 23 is the granularity flag and bits 31:24 are the rights byte, with bit 31 the present flag. Fault codes: 0 none, 1 null, 2 limit, 3 alignment, 4 table, 5 not present.

Top module: `segx_unit`

## Requirements
- R1: After reset every slot and the local-table register are null, `ld_ready` and `acc_ready` are 1, `ld_done`, `acc_done` and `mem_req` are 0, and an access to any slot reports fault 1.
- R2: Loading a selector whose bits 15:2 are all zero issues no memory read. `ld_done` pulses the cycle after acceptance with fault 0, and later accesses through that slot report fault 1, which takes priority over all other faults.
- R3: A load that passes the table check issues exactly two reads, at table base + 8·index and then at that address + 4. It caches the lower word as the base and the upper word's fields as described above. The requested-privilege bits 1:0 have no effect.
- R4: From the cycle a fetching load is accepted until its `ld_done` pulse, `acc_ready` and `ld_ready` are 0, and an `acc_valid` in that window produces no `acc_done`.
- R5: An accepted access with no fault returns `acc_lin` = cached base + offset (modulo 2^32), with `acc_done` high in the following cycle.
- R6: With granularity 0, an access of 2^size bytes (size 0 byte, 1 word, 2 doubleword, 3 quadword) faults with code 2 when offset + 2^size − 1 > limit. The sum is computed without wrap-around.
- R7: With granularity 1, the effective limit is limit·4096 + 4095.
- R8: With `align_en` = 1, an access whose offset is not a multiple of 2^size faults with code 3; with `align_en` = 0 it does not. A limit fault takes priority over an alignment fault.
- R9: After a load, changing the descriptor in memory does not change the results of accesses through that slot, and accesses issue no memory read.
- R10: A selector whose last descriptor byte (8·index + 7) lies above the table's byte limit is rejected with code 4, without a memory read, and the target slot becomes null.
- R11: A fetched descriptor whose present bit is 0 completes with code 5 and leaves the target slot null.
- R12: With `ld_ldt` = 1 the load targets the local-table register, and a selector with bit 2 set is then rejected with code 4. Selectors with bit 2 set use the cached local-table base and effective limit, and are rejected with code 4 while the local-table register is null.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| gdt_base | input | 32 | Global table base address |
| gdt_limit | input | 16 | Global table byte limit |
| ld_valid | input | 1 | Load request |
| ld_ldt | input | 1 | Load targets the local-table register instead of a slot |
| ld_slot | input | SLOT_W | Target slot of a load |
| ld_sel | input | 16 | Selector to load |
| ld_ready | output | 1 | Load can be accepted |
| ld_done | output | 1 | One-cycle pulse: load finished |
| ld_fault | output | 3 | Fault code of the finished load |
| mem_req | output | 1 | Read request, held until acknowledged |
| mem_addr | output | 32 | Read address |
| mem_ack | input | 1 | Read acknowledge, data valid |
| mem_rdata | input | 32 | Read data |
| acc_valid | input | 1 | Access request |
| acc_slot | input | SLOT_W | Slot used by the access |
| acc_off | input | 32 | Access offset |
| acc_size | input | 2 | log2 of the access byte count |
| align_en | input | 1 | Enable the alignment check |
| acc_ready | output | 1 | Access can be accepted |
| acc_done | output | 1 | One-cycle pulse: access result valid |
| acc_lin | output | 32 | Linear address |
| acc_fault | output | 3 | Access fault code |

## Verification
The bench aims at the boundary of every limit. It checks the last legal byte and the first illegal one for byte and scaled segments, and a multi-byte access that straddles the limit. A design that compares only the offset, or forgets the 4095 tail of a scaled limit, passes or rejects the wrong one. It probes an offset near 2^32, where a wrapping sum would wrongly pass, and it checks the priority among null, limit and alignment faults. It rewrites a descriptor in memory after loading it, which exposes a design that re-reads instead of using its cache. It also covers table-limit edges, the local-table chain, and accesses offered during a fetch, which a design that ignores the stall would answer.

// File: rtl/segx_pkg.sv
package segx_pkg;
   localparam int ADDR_W   = 32;
   localparam int LIM_W    = 20;
   localparam int RIGHTS_W = 8;
   localparam int GRAN_SH  = 12;
   localparam int SEL_W    = 16;

   typedef enum logic [2:0] {
      FLT_NONE   = 3'd0,
      FLT_NULL   = 3'd1,
      FLT_LIMIT  = 3'd2,
      FLT_ALIGN  = 3'd3,
      FLT_TABLE  = 3'd4,
      FLT_ABSENT = 3'd5
   } flt_e;

   typedef struct packed {
      logic                live;
      logic [ADDR_W-1:0]   base;
      logic [LIM_W-1:0]    limit;
      logic                gran;
      logic [RIGHTS_W-1:0] rights;
   } seg_ent_t;

   function automatic logic [ADDR_W-1:0] eff_limit(input seg_ent_t e);
      logic [LIM_W+GRAN_SH-1:0] wide;
      wide = e.gran ? {e.limit, {GRAN_SH{1'b1}}} : {{GRAN_SH{1'b0}}, e.limit};
      return ADDR_W'(wide);
   endfunction
endpackage

// File: rtl/segx_fetch.sv
module segx_fetch
   import segx_pkg::*;
#(
   parameter int SLOT_W      = 2,
   parameter int GRAN_BIT    = 23,
   parameter int RIGHTS_LSB  = 24,
   parameter int PRESENT_BIT = 31
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ld_valid,
   input  logic                ld_ldt,
   input  logic [SLOT_W-1:0]   ld_slot,
   input  logic [SEL_W-1:0]    ld_sel,
   input  logic [ADDR_W-1:0]   gbase,
   input  logic [SEL_W-1:0]    glimit,
   input  seg_ent_t            ldt_ent,
   input  logic                mem_ack,
   input  logic [ADDR_W-1:0]   mem_rdata,
   output logic                idle,
   output logic                mem_req,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic                wr_en,
   output logic                wr_ldt,
   output logic [SLOT_W-1:0]   wr_slot,
   output seg_ent_t            wr_ent,
   output logic                ld_done,
   output logic [2:0]          ld_fault
);
   localparam int IDX_W = SEL_W - 3;

   typedef enum logic [1:0] {ST_IDLE, ST_LO, ST_HI} st_e;

   st_e                st;
   logic               tgt_ldt;
   logic [SLOT_W-1:0]  tgt_slot;
   logic [ADDR_W-1:0]  addr_q;
   logic [ADDR_W-1:0]  word_lo;
   logic               done_q;
   flt_e               fault_q;

   logic               ti;
   logic [IDX_W-1:0]   idx;
   logic               sel_null;
   logic [ADDR_W-1:0]  tab_lim;
   logic [ADDR_W-1:0]  tab_base;
   logic [ADDR_W-1:0]  span_end;
   logic               accept;
   logic               need_fetch;
   flt_e               chk_flt;
   logic               hi_ok;
   logic               unused_bits;

   assign ti       = ld_sel[2];
   assign idx      = ld_sel[SEL_W-1:3];
   assign sel_null = (idx == '0) && !ti;
   assign tab_lim  = ti ? eff_limit(ldt_ent) : ADDR_W'(glimit);
   assign tab_base = ti ? ldt_ent.base : gbase;
   assign span_end = ADDR_W'({idx, 3'b111});
   assign accept   = (st == ST_IDLE) && ld_valid;
   assign hi_ok    = mem_rdata[PRESENT_BIT];
   assign unused_bits = ^{ld_sel[1:0], ldt_ent.rights, mem_rdata[GRAN_BIT-1:LIM_W]};

   always_comb begin
      chk_flt    = FLT_NONE;
      need_fetch = 1'b0;
      if (sel_null) begin
         chk_flt = FLT_NONE;
      end else if (ti && (ld_ldt || !ldt_ent.live)) begin
         chk_flt = FLT_TABLE;
      end else if (span_end > tab_lim) begin
         chk_flt = FLT_TABLE;
      end else begin
         need_fetch = 1'b1;
      end
   end

   always_comb begin
      wr_en   = (accept && !need_fetch) || ((st == ST_HI) && mem_ack);
      wr_ldt  = (st == ST_IDLE) ? ld_ldt  : tgt_ldt;
      wr_slot = (st == ST_IDLE) ? ld_slot : tgt_slot;
      wr_ent  = '0;
      if ((st == ST_HI) && hi_ok) begin
         wr_ent.live   = 1'b1;
         wr_ent.base   = word_lo;
         wr_ent.limit  = mem_rdata[LIM_W-1:0];
         wr_ent.gran   = mem_rdata[GRAN_BIT];
         wr_ent.rights = mem_rdata[RIGHTS_LSB +: RIGHTS_W];
      end
   end

   assign idle     = (st == ST_IDLE);
   assign mem_req  = (st != ST_IDLE);
   assign mem_addr = addr_q;
   assign ld_done  = done_q;
   assign ld_fault = fault_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         tgt_ldt  <= 1'b0;
         tgt_slot <= '0;
         addr_q   <= '0;
         word_lo  <= '0;
         done_q   <= 1'b0;
         fault_q  <= FLT_NONE;
      end else begin
         done_q <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (accept) begin
                  if (need_fetch) begin
                     st       <= ST_LO;
                     tgt_ldt  <= ld_ldt;
                     tgt_slot <= ld_slot;
                     addr_q   <= tab_base + ADDR_W'({idx, 3'b000});
                  end else begin
                     done_q  <= 1'b1;
                     fault_q <= chk_flt;
                  end
               end
            end
            ST_LO: begin
               if (mem_ack) begin
                  word_lo <= mem_rdata;
                  addr_q  <= addr_q + ADDR_W'(4);
                  st      <= ST_HI;
               end
            end
            ST_HI: begin
               if (mem_ack) begin
                  st      <= ST_IDLE;
                  done_q  <= 1'b1;
                  fault_q <= hi_ok ? FLT_NONE : FLT_ABSENT;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/segx_cache.sv
module segx_cache
   import segx_pkg::*;
#(
   parameter int NSEG   = 4,
   parameter int SLOT_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               wr_ldt,
   input  logic [SLOT_W-1:0]  wr_slot,
   input  seg_ent_t           wr_ent,
   input  logic [SLOT_W-1:0]  rd_slot,
   output seg_ent_t           rd_ent,
   output seg_ent_t           ldt_ent
);
   seg_ent_t ent_arr [NSEG];
   seg_ent_t ldt_q;

   for (genvar g = 0; g < NSEG; g++) begin : g_slot
      seg_ent_t q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q <= '0;
         end else if (wr_en && !wr_ldt && (wr_slot == SLOT_W'(g))) begin
            q <= wr_ent;
         end
      end
      assign ent_arr[g] = q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ldt_q <= '0;
      end else if (wr_en && wr_ldt) begin
         ldt_q <= wr_ent;
      end
   end

   assign rd_ent  = ent_arr[rd_slot];
   assign ldt_ent = ldt_q;
endmodule

// File: rtl/segx_check.sv
module segx_check
   import segx_pkg::*;
#(
   parameter bit ALIGN_CHK = 1'b1
) (
   input  seg_ent_t           ent,
   input  logic [ADDR_W-1:0]  off,
   input  logic [1:0]         size,
   input  logic               align_en,
   output flt_e               fault,
   output logic [ADDR_W-1:0]  lin
);
   logic [ADDR_W:0]   end_off;
   logic [ADDR_W-1:0] lim;
   logic [3:0]        span_m1;
   logic              over;
   logic              mis;
   logic              unused_bits;

   assign span_m1 = 4'((5'd1 << size) - 5'd1);
   assign end_off = {1'b0, off} + (ADDR_W+1)'(span_m1);
   assign lim     = eff_limit(ent);
   assign over    = end_off > {1'b0, lim};
   assign unused_bits = ^{ent.rights, span_m1[3]};

   if (ALIGN_CHK) begin : g_align
      assign mis = align_en && ((off[2:0] & span_m1[2:0]) != 3'b000);
   end else begin : g_noalign
      logic unused_align;
      assign unused_align = align_en;
      assign mis = 1'b0;
   end

   always_comb begin
      if (!ent.live)  fault = FLT_NULL;
      else if (over)  fault = FLT_LIMIT;
      else if (mis)   fault = FLT_ALIGN;
      else            fault = FLT_NONE;
   end

   assign lin = ent.base + off;
endmodule

// File: rtl/segx_unit.sv
module segx_unit
   import segx_pkg::*;
#(
   parameter int NSEG      = 4,
   parameter int SLOT_W    = $clog2(NSEG),
   parameter bit ALIGN_CHK = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [31:0]        gdt_base,
   input  logic [15:0]        gdt_limit,
   input  logic               ld_valid,
   input  logic               ld_ldt,
   input  logic [SLOT_W-1:0]  ld_slot,
   input  logic [15:0]        ld_sel,
   output logic               ld_ready,
   output logic               ld_done,
   output logic [2:0]         ld_fault,
   output logic               mem_req,
   output logic [31:0]        mem_addr,
   input  logic               mem_ack,
   input  logic [31:0]        mem_rdata,
   input  logic               acc_valid,
   input  logic [SLOT_W-1:0]  acc_slot,
   input  logic [31:0]        acc_off,
   input  logic [1:0]         acc_size,
   input  logic               align_en,
   output logic               acc_ready,
   output logic               acc_done,
   output logic [31:0]        acc_lin,
   output logic [2:0]         acc_fault
);
   if (NSEG < 2 || NSEG != (1 << SLOT_W)) begin : g_bad_nseg
      $error("segx_unit: NSEG must be a power of two of at least 2");
   end
   if (ADDR_W != 32 || SEL_W != 16) begin : g_bad_width
      $error("segx_unit: port widths assume 32-bit addresses and 16-bit selectors");
   end

   logic               idle;
   logic               wr_en;
   logic               wr_ldt;
   logic [SLOT_W-1:0]  wr_slot;
   seg_ent_t           wr_ent;
   seg_ent_t           rd_ent;
   seg_ent_t           ldt_ent;
   flt_e               chk_fault;
   logic [ADDR_W-1:0]  chk_lin;

   logic               acc_done_q;
   logic [ADDR_W-1:0]  acc_lin_q;
   flt_e               acc_fault_q;

   segx_fetch #(.SLOT_W(SLOT_W)) u_fetch (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_valid  (ld_valid),
      .ld_ldt    (ld_ldt),
      .ld_slot   (ld_slot),
      .ld_sel    (ld_sel),
      .gbase     (gdt_base),
      .glimit    (gdt_limit),
      .ldt_ent   (ldt_ent),
      .mem_ack   (mem_ack),
      .mem_rdata (mem_rdata),
      .idle      (idle),
      .mem_req   (mem_req),
      .mem_addr  (mem_addr),
      .wr_en     (wr_en),
      .wr_ldt    (wr_ldt),
      .wr_slot   (wr_slot),
      .wr_ent    (wr_ent),
      .ld_done   (ld_done),
      .ld_fault  (ld_fault)
   );

   segx_cache #(.NSEG(NSEG), .SLOT_W(SLOT_W)) u_cache (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_ldt  (wr_ldt),
      .wr_slot (wr_slot),
      .wr_ent  (wr_ent),
      .rd_slot (acc_slot),
      .rd_ent  (rd_ent),
      .ldt_ent (ldt_ent)
   );

   segx_check #(.ALIGN_CHK(ALIGN_CHK)) u_check (
      .ent      (rd_ent),
      .off      (acc_off),
      .size     (acc_size),
      .align_en (align_en),
      .fault    (chk_fault),
      .lin      (chk_lin)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_done_q  <= 1'b0;
         acc_lin_q   <= '0;
         acc_fault_q <= FLT_NONE;
      end else begin
         acc_done_q <= acc_valid && idle;
         if (acc_valid && idle) begin
            acc_fault_q <= chk_fault;
            acc_lin_q   <= (chk_fault == FLT_NONE) ? chk_lin : '0;
         end
      end
   end

   assign ld_ready  = idle;
   assign acc_ready = idle;
   assign acc_done  = acc_done_q;
   assign acc_lin   = acc_lin_q;
   assign acc_fault = acc_fault_q;
endmodule

// File: rtl/segx_chk.sv
module segx_chk #(
   parameter bit ALIGN_CHK = 1'b1
) (
   input logic        clk,
   input logic        rst_n,
   input logic        ld_valid,
   input logic        ld_ready,
   input logic [15:0] ld_sel,
   input logic        ld_done,
   input logic [2:0]  ld_fault,
   input logic        mem_req,
   input logic        mem_ack,
   input logic [31:0] mem_addr,
   input logic        acc_valid,
   input logic        acc_ready,
   input logic        acc_done,
   input logic [2:0]  acc_fault,
   input logic [1:0]  acc_size,
   input logic [2:0]  acc_off_lo,
   input logic        align_en
);
   AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !ld_ready && !acc_ready);                                   // R4

   AST_NO_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_ready && acc_valid) |=> !acc_done);                              // R4

   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> $stable(mem_addr));                          // R3

   AST_NULL_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && ld_ready && ld_sel[15:2] == 14'd0) |=> !mem_req && ld_done); // R2

   AST_LOAD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      ld_done |-> (ld_fault == 3'd0 || ld_fault == 3'd4 || ld_fault == 3'd5)); // R10

   AST_NO_ALIGN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_done && !$past(align_en)) |-> acc_fault != 3'd3);                 // R8

   AST_DWORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (ALIGN_CHK && acc_done && acc_fault == 3'd0 && $past(align_en) && $past(acc_size) == 2'd2)
         |-> $past(acc_off_lo[1:0]) == 2'b00);                               // R8
endmodule

bind segx_unit segx_chk #(.ALIGN_CHK(ALIGN_CHK)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ld_valid   (ld_valid),
   .ld_ready   (ld_ready),
   .ld_sel     (ld_sel),
   .ld_done    (ld_done),
   .ld_fault   (ld_fault),
   .mem_req    (mem_req),
   .mem_ack    (mem_ack),
   .mem_addr   (mem_addr),
   .acc_valid  (acc_valid),
   .acc_ready  (acc_ready),
   .acc_done   (acc_done),
   .acc_fault  (acc_fault),
   .acc_size   (acc_size),
   .acc_off_lo (acc_off[2:0]),
   .align_en   (align_en)
);

// File: tb/sim_segx_unit.sv
`timescale 1ns/1ps
module sim_segx_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] gdt_base = 32'h0000_1000;
   logic [15:0] gdt_limit = 16'h007F;
   logic        ld_valid = 1'b0, ld_ldt = 1'b0;
   logic [1:0]  ld_slot = '0;
   logic [15:0] ld_sel = '0;
   logic        ld_ready, ld_done;
   logic [2:0]  ld_fault;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_ack;
   logic [31:0] mem_rdata;
   logic        acc_valid = 1'b0;
   logic [1:0]  acc_slot = '0;
   logic [31:0] acc_off = '0;
   logic [1:0]  acc_size = '0;
   logic        align_en = 1'b0;
   logic        acc_ready, acc_done;
   logic [31:0] acc_lin;
   logic [2:0]  acc_fault;

   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;

   segx_unit u0 (.*);

   // Memory model: 64 words, acknowledges one cycle after a request.
   logic [31:0] mem [64];
   int          rd_cnt = 0;
   logic [31:0] a_last = '0, a_prev = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack   <= 1'b0;
         mem_rdata <= '0;
      end else if (mem_req && !mem_ack) begin
         mem_ack   <= 1'b1;
         mem_rdata <= mem[mem_addr[7:2]];
         rd_cnt    <= rd_cnt + 1;
         a_prev    <= a_last;
         a_last    <= mem_addr;
      end else begin
         mem_ack <= 1'b0;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_load(input bit ldt, input logic [1:0] slot, input logic [15:0] sel,
                          input logic [2:0] efault, input int ereads, input logic [31:0] eaddr,
                          input bit stall, input string req);
      int c0;
      @(negedge clk);
      c0 = rd_cnt;
      ld_valid = 1'b1; ld_ldt = ldt; ld_slot = slot; ld_sel = sel;
      @(negedge clk);
      ld_valid = 1'b0; ld_ldt = 1'b0;
      if (stall) begin
         chk(acc_ready == 1'b0 && ld_ready == 1'b0, req, {30'd0, acc_ready, ld_ready}, 32'd0);
         acc_valid = 1'b1; acc_slot = slot;
         @(negedge clk);
         acc_valid = 1'b0;
         chk(acc_done == 1'b0, req, {31'd0, acc_done}, 32'd0);
      end
      for (int i = 0; i < 40 && !ld_done; i++) @(negedge clk);
      chk(ld_done == 1'b1, req, {31'd0, ld_done}, 32'd1);
      chk(ld_fault == efault, req, {29'd0, ld_fault}, {29'd0, efault});
      chk(rd_cnt - c0 == ereads, req, rd_cnt - c0, ereads);
      if (ereads == 2) chk(a_prev == eaddr, req, a_prev, eaddr);
   endtask

   task automatic do_acc(input logic [1:0] slot, input logic [31:0] off, input logic [1:0] sz,
                         input bit al, input logic [2:0] efault, input logic [31:0] elin,
                         input string req);
      int c0;
      @(negedge clk);
      c0 = rd_cnt;
      acc_valid = 1'b1; acc_slot = slot; acc_off = off; acc_size = sz; align_en = al;
      @(negedge clk);
      acc_valid = 1'b0;
      chk(acc_done == 1'b1, req, {31'd0, acc_done}, 32'd1);
      chk(acc_fault == efault, req, {29'd0, acc_fault}, {29'd0, efault});
      if (efault == 3'd0) chk(acc_lin == elin, req, acc_lin, elin);
      chk(rd_cnt == c0, req, rd_cnt, c0);
   endtask

   typedef struct packed {
      logic [1:0]  slot;
      logic [31:0] off;
      logic [1:0]  sz;
      logic        al;
      logic [2:0]  flt;
      logic [31:0] lin;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t VEC [NV] = '{
      '{2'd0, 32'h0000_0010, 2'd0, 1'b0, 3'd0, 32'h0001_0010},
      '{2'd0, 32'h0000_00FF, 2'd0, 1'b0, 3'd0, 32'h0001_00FF},
      '{2'd0, 32'h0000_00FF, 2'd1, 1'b0, 3'd2, 32'h0},
      '{2'd0, 32'h0000_00FE, 2'd1, 1'b0, 3'd0, 32'h0001_00FE},
      '{2'd0, 32'h0000_00FC, 2'd2, 1'b0, 3'd0, 32'h0001_00FC},
      '{2'd0, 32'h0000_00FD, 2'd2, 1'b0, 3'd2, 32'h0},
      '{2'd0, 32'h0000_0011, 2'd1, 1'b1, 3'd3, 32'h0},
      '{2'd0, 32'h0000_0011, 2'd1, 1'b0, 3'd0, 32'h0001_0011},
      '{2'd0, 32'h0000_0012, 2'd2, 1'b1, 3'd3, 32'h0},
      '{2'd0, 32'h0000_00FF, 2'd1, 1'b1, 3'd2, 32'h0},
      '{2'd1, 32'h0000_2FFF, 2'd0, 1'b0, 3'd0, 32'h0020_2FFF},
      '{2'd1, 32'h0000_2FFE, 2'd1, 1'b1, 3'd0, 32'h0020_2FFE},
      '{2'd1, 32'h0000_3000, 2'd0, 1'b0, 3'd2, 32'h0},
      '{2'd1, 32'h0000_2FFD, 2'd2, 1'b0, 3'd2, 32'h0},
      '{2'd2, 32'h0000_0000, 2'd0, 1'b0, 3'd1, 32'h0},
      '{2'd3, 32'h0000_0000, 2'd0, 1'b0, 3'd1, 32'h0},
      '{2'd0, 32'hFFFF_FFFF, 2'd2, 1'b0, 3'd2, 32'h0},
      '{2'd1, 32'h0000_2FFC, 2'd2, 1'b1, 3'd0, 32'h0020_2FFC}
   };

   function automatic string vec_tag(input vec_t v);
      if (v.flt == 3'd1)       return "R2";
      else if (v.slot == 2'd1) return "R7";
      else if (v.flt == 3'd3 || v.al) return "R8";
      else if (v.flt == 3'd2)  return "R6";
      else                     return "R5";
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = 32'h0;
      mem[2]  = 32'h0001_0000; mem[3]  = 32'h9200_00FF;  // global 1: byte limit 0xFF
      mem[4]  = 32'h0020_0000; mem[5]  = 32'h9280_0002;  // global 2: scaled limit
      mem[6]  = 32'h0000_0000; mem[7]  = 32'h1200_0010;  // global 3: not present
      mem[10] = 32'h0000_1060; mem[11] = 32'h8200_000F;  // global 5: local table
      mem[26] = 32'h0300_0000; mem[27] = 32'h9200_FFFF;  // local 1
      mem[30] = 32'h0040_0000; mem[31] = 32'h9200_0010;  // global 15: last entry

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(ld_ready && acc_ready, "R1", {30'd0, ld_ready, acc_ready}, 32'd3);
      chk(!ld_done && !acc_done && !mem_req, "R1", {29'd0, ld_done, acc_done, mem_req}, 32'd0);
      do_acc(2'd0, 32'h0, 2'd0, 1'b0, 3'd1, 32'h0, "R1");
      do_acc(2'd3, 32'h4, 2'd2, 1'b1, 3'd1, 32'h0, "R1");

      // R3 / R4: fetch with privilege bits set, stall window probed
      do_load(1'b0, 2'd0, 16'h000B, 3'd0, 2, 32'h0000_1008, 1'b1, "R3");
      do_load(1'b0, 2'd1, 16'h0010, 3'd0, 2, 32'h0000_1010, 1'b1, "R4");
      // R2 null selector
      do_load(1'b0, 2'd2, 16'h0003, 3'd0, 0, 32'h0, 1'b0, "R2");
      // R11 not present
      do_load(1'b0, 2'd3, 16'h0018, 3'd5, 2, 32'h0000_1018, 1'b0, "R11");

      for (int v = 0; v < NV; v++)
         do_acc(VEC[v].slot, VEC[v].off, VEC[v].sz, VEC[v].al, VEC[v].flt, VEC[v].lin, vec_tag(VEC[v]));

      // R9 cached copy survives memory change
      mem[2] = 32'h0555_0000; mem[3] = 32'h9200_FFFF;
      do_acc(2'd0, 32'h0000_0020, 2'd0, 1'b0, 3'd0, 32'h0001_0020, "R9");
      do_acc(2'd0, 32'h0000_0100, 2'd0, 1'b0, 3'd2, 32'h0, "R9");

      // R12 local table chain
      do_load(1'b0, 2'd2, 16'h000C, 3'd4, 0, 32'h0, 1'b0, "R12");
      do_load(1'b1, 2'd0, 16'h000C, 3'd4, 0, 32'h0, 1'b0, "R12");
      do_load(1'b1, 2'd0, 16'h0028, 3'd0, 2, 32'h0000_1028, 1'b0, "R12");
      do_acc(2'd0, 32'h0000_0020, 2'd0, 1'b0, 3'd0, 32'h0001_0020, "R12");
      do_load(1'b0, 2'd2, 16'h000C, 3'd0, 2, 32'h0000_1068, 1'b0, "R12");
      do_acc(2'd2, 32'h0000_1234, 2'd2, 1'b1, 3'd0, 32'h0300_1234, "R12");
      do_acc(2'd2, 32'h0001_0000, 2'd0, 1'b0, 3'd2, 32'h0, "R12");
      do_load(1'b0, 2'd3, 16'h0014, 3'd4, 0, 32'h0, 1'b0, "R12");

      // R10 global table limit edge
      do_load(1'b0, 2'd3, 16'h0078, 3'd0, 2, 32'h0000_1078, 1'b0, "R10");
      do_acc(2'd3, 32'h0000_0010, 2'd0, 1'b0, 3'd0, 32'h0040_0010, "R10");
      do_load(1'b0, 2'd3, 16'h0080, 3'd4, 0, 32'h0, 1'b0, "R10");
      do_acc(2'd3, 32'h0000_0010, 2'd0, 1'b0, 3'd1, 32'h0, "R10");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule